// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the device-side receiver of a framed serial configuration port on a dual-channel converter. An external host pulls an active-low select line low and clocks in bits on a serial clock. The block samples each bit on a falling serial-clock edge. The first four bits form a write address and the next twelve form a control word, most significant bit first. A seventeenth falling edge transfers the word into the control register. The register fields come out as separate outputs: the readout register selector, the calibration request, the power-down mode and the front-end amplifier gain.

The serial clock, the select line and the data line are resynchronised into a faster system clock. Serial-clock edges are found in that domain, so all logic runs on one clock. Each phase of the serial clock must therefore last at least two system clocks. A frame is discarded when it carries a different write address, or when the select line rises before the seventeenth edge. Each accepted commit produces a one-cycle strobe. A separate one-cycle pulse marks a commit in which the calibration bit goes from clear to set. After reset every field is zero, which in register mode means both converters and the comparators are powered down at unity gain.

Top module: `ser_cfg_port`

## Requirements
- R1: Serial-clock falling edges that occur while `cs_n` is high shift nothing and never change the register.
- R2: A frame is four address bits followed by twelve data bits, each taken from `sdi` on a falling edge of `sclk`, most significant bit first.
- R3: The word is written only on the 17th falling edge of a frame; a frame of 16 or fewer edges leaves the register unchanged.
- R4: Register bit positions: bits 11:8 drive `rd_sel`, bit 7 drives `cal_en`, bits 6:4 drive `pd_mode`, bits 3:0 drive `gain`.
- R5: After reset every field output is zero, and `cfg_valid` and `cal_start` are low.
- R6: A frame whose four address bits differ from the parameter `CTRL_ADDR` (default 4'b0001) leaves the register unchanged and raises no strobe.
- R7: Raising `cs_n` mid-frame clears the bit count, so the next frame is received from its first bit.
- R8: `cfg_valid` is high for exactly one system clock on each accepted commit, in the same cycle in which the new field values first appear.
- R9: `cal_start` pulses for one system clock on a commit that sets bit 7 while the register held bit 7 clear; a commit that keeps bit 7 set or clears it gives no pulse.
- R10: Falling edges after the 17th in the same frame are ignored; the committed word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| sdi | input | 1 | Serial data in, sampled on falling `sclk` |
| rd_sel | output | 4 | Readout register selector field |
| cal_en | output | 1 | Calibration request bit |
| pd_mode | output | 3 | Power-down mode field |
| gain | output | 4 | Amplifier gain select field |
| cfg_valid | output | 1 | One-cycle strobe on each accepted commit |
| cal_start | output | 1 | One-cycle pulse when the calibration bit rises |

## Verification
Directed frames set one field at a time with the other bits zero, so a swapped or shifted field shows up as a wrong output. Frames with the wrong address, short frames, frames with extra clocks, and clock toggling with select high each leave the register unchanged or unchanged past the 17th edge. These cases separate the address decode from the edge counter from the select gating. Sequences of calibration bit values 0→1, 1→1 and 1→0 tell a rising-edge detector apart from a plain level copy. A seeded random run mixes addresses, data and frame lengths against a bench model of the register and the strobe counts.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 12;

    typedef struct packed {
        logic [3:0] rd_sel;
        logic       cal;
        logic [2:0] pd;
        logic [3:0] gain;
    } ctrl_word_t;

    function automatic ctrl_word_t to_ctrl(input logic [DATA_W-1:0] w);
        return ctrl_word_t'(w);
    endfunction

    function automatic logic cal_rises(input ctrl_word_t old_w, input ctrl_word_t new_w);
        return new_w.cal & ~old_w.cal;
    endfunction

endpackage

// File: rtl/ser_sync_edge.sv
module ser_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic fall_seen,
    output logic sel_active,
    output logic sdi_s
);
    localparam int W = 3;

    logic [W-1:0] chain [STAGES];
    logic         sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= 3'b011;
            sclk_prev <= 1'b1;
        end else begin
            chain[0] <= {sdi, cs_n, sclk};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sclk_prev <= chain[STAGES-1][0];
        end
    end

    assign fall_seen  = sclk_prev & ~chain[STAGES-1][0];
    assign sel_active = ~chain[STAGES-1][1];
    assign sdi_s      = chain[STAGES-1][2];

endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift import ser_cfg_pkg::*; #(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'b0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_seen,
    input  logic              sel_active,
    input  logic              sdi_s,
    output logic              commit,
    output logic [DATA_W-1:0] word
);
    localparam int BITS  = ADDR_W + DATA_W;
    localparam int LAST  = BITS + 1;
    localparam int CNT_W = $clog2(LAST + 1);

    logic [BITS-1:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic             addr_hit;

    assign addr_hit = (shreg[BITS-1 -: ADDR_W] == CTRL_ADDR);
    assign word     = shreg[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            cnt    <= '0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (!sel_active) begin
                cnt <= '0;
            end else if (fall_seen) begin
                if (cnt < CNT_W'(BITS)) begin
                    shreg <= {shreg[BITS-2:0], sdi_s};
                    cnt   <= cnt + 1'b1;
                end else if (cnt == CNT_W'(BITS)) begin
                    cnt    <= CNT_W'(LAST);
                    commit <= addr_hit;
                end
            end
        end
    end

endmodule

// File: rtl/ser_ctrl_reg.sv
module ser_ctrl_reg import ser_cfg_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [DATA_W-1:0] word,
    output ctrl_word_t        ctrl,
    output logic              cfg_valid,
    output logic              cal_start
);
    ctrl_word_t next_w;
    assign next_w = to_ctrl(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            cfg_valid <= 1'b0;
            cal_start <= 1'b0;
        end else begin
            cfg_valid <= commit;
            cal_start <= commit & cal_rises(ctrl, next_w);
            if (commit) ctrl <= next_w;
        end
    end

endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port import ser_cfg_pkg::*; #(
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'b0001,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdi,
    output logic [3:0] rd_sel,
    output logic       cal_en,
    output logic [2:0] pd_mode,
    output logic [3:0] gain,
    output logic       cfg_valid,
    output logic       cal_start
);
    logic              fall_seen, sel_active, sdi_s, commit;
    logic [DATA_W-1:0] word;
    ctrl_word_t        ctrl;

    ser_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .fall_seen(fall_seen), .sel_active(sel_active), .sdi_s(sdi_s)
    );

    ser_frame_shift #(.CTRL_ADDR(CTRL_ADDR)) u_shift (
        .clk(clk), .rst(rst), .fall_seen(fall_seen), .sel_active(sel_active),
        .sdi_s(sdi_s), .commit(commit), .word(word)
    );

    ser_ctrl_reg u_reg (
        .clk(clk), .rst(rst), .commit(commit), .word(word),
        .ctrl(ctrl), .cfg_valid(cfg_valid), .cal_start(cal_start)
    );

    assign rd_sel  = ctrl.rd_sel;
    assign cal_en  = ctrl.cal;
    assign pd_mode = ctrl.pd;
    assign gain    = ctrl.gain;

endmodule

// File: rtl/ser_cfg_port_chk.sv
module ser_cfg_port_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] rd_sel,
    input logic       cal_en,
    input logic [2:0] pd_mode,
    input logic [3:0] gain,
    input logic       cfg_valid,
    input logic       cal_start
);
    logic [11:0] fields;
    assign fields = {rd_sel, cal_en, pd_mode, gain};

    a_r5_reset_zero: assert property (@(posedge clk)
        rst |=> (fields == 12'd0 && !cfg_valid && !cal_start));

    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> !cfg_valid);

    a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |-> $stable(fields));

    a_r9_cal_with_commit: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> cfg_valid);

    a_r9_cal_is_rise: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> (cal_en && !$past(cal_en)));

    a_r9_no_cal_on_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && $past(cal_en)) |-> !cal_start);

endmodule

bind ser_cfg_port ser_cfg_port_chk u_chk (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .cal_en(cal_en), .pd_mode(pd_mode),
    .gain(gain), .cfg_valid(cfg_valid), .cal_start(cal_start)
);

// File: tb/ser_cfg_port_bench.sv
module ser_cfg_port_bench;
    localparam logic [3:0] CA = 4'b0001;

    logic       clk = 1'b0, rst = 1'b1, sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0;
    logic [3:0] rd_sel, gain;
    logic [2:0] pd_mode;
    logic       cal_en, cfg_valid, cal_start;

    int errs = 0, checks = 0, vcnt = 0, ccnt = 0;
    logic [11:0] model = 12'd0;

    always #2 clk = ~clk;

    ser_cfg_port u_ser_cfg_port (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .rd_sel(rd_sel), .cal_en(cal_en), .pd_mode(pd_mode), .gain(gain),
        .cfg_valid(cfg_valid), .cal_start(cal_start)
    );

    always @(negedge clk) if (!rst) begin
        if (cfg_valid) vcnt++;
        if (cal_start) ccnt++;
    end

    function automatic logic [11:0] obs();
        return {rd_sel, cal_en, pd_mode, gain};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // expected effect of one frame, from the requirements
    task automatic frame(input logic [3:0] a, input logic [11:0] d, input int n, input string tag);
        logic [15:0] bits;
        logic [11:0] expw;
        int v0, c0, ev, ec;
        bits = {a, d};
        v0 = vcnt; c0 = ccnt; expw = model; ev = 0; ec = 0;
        if (n >= 17 && a == CA) begin
            ev = 1;
            ec = (d[7] && !model[7]) ? 1 : 0;
            expw = d;
        end
        cs_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < n; i++) begin
            sdi  = (i < 16) ? bits[15-i] : 1'($urandom);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
            wait_clk(3);
        end
        sclk = 1'b1;
        wait_clk(3);
        cs_n = 1'b1;
        sdi  = 1'b0;
        wait_clk(6);
        model = expw;
        @(negedge clk);
        chk(obs() == expw, tag, int'(obs()), int'(expw));
        chk(vcnt - v0 == ev, "R8 valid count", vcnt - v0, ev);
        chk(ccnt - c0 == ec, "R9 cal pulse count", ccnt - c0, ec);
    endtask

    initial begin
        #800000;
        errs++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        @(negedge clk);
        chk(obs() == 12'd0, "R5 fields after reset", int'(obs()), 0);
        chk(!cfg_valid && !cal_start, "R5 strobes after reset", int'({cfg_valid, cal_start}), 0);

        // R1: clocking with select high
        begin
            logic [15:0] b;
            int v0;
            b = {CA, 12'hFFF};
            v0 = vcnt;
            for (int i = 0; i < 17; i++) begin
                sdi = (i < 16) ? b[15-i] : 1'b0;
                sclk = 1'b1; wait_clk(3);
                sclk = 1'b0; wait_clk(3);
            end
            sclk = 1'b1; wait_clk(6);
            @(negedge clk);
            chk(obs() == 12'd0, "R1 ignored while deselected", int'(obs()), 0);
            chk(vcnt == v0, "R1 no strobe while deselected", vcnt - v0, 0);
        end

        frame(CA, 12'hF00, 17, "R4 rd_sel field");
        frame(CA, 12'h070, 17, "R4 pd_mode field");
        frame(CA, 12'h00F, 17, "R4 gain field");
        frame(CA, 12'h0A5, 17, "R2/R4 mixed word with cal");
        frame(CA, 12'h0B3, 17, "R9 cal held set");
        frame(CA, 12'h012, 17, "R9 cal cleared");
        frame(CA, 12'h080, 17, "R9 cal rise again");
        frame(4'h2, 12'h5C3, 17, "R6 wrong address");
        frame(4'h9, 12'h001, 17, "R6 wrong address high bit");
        frame(CA, 12'h3C6, 16, "R3 sixteen edges only");
        frame(CA, 12'hE1D, 9, "R7 aborted frame");
        frame(CA, 12'h6B4, 17, "R7 frame after abort");
        frame(CA, 12'h249, 20, "R10 extra edges ignored");

        for (int k = 0; k < 40; k++) begin
            logic [3:0] a;
            int n, sel;
            a   = ($urandom_range(9, 0) < 7) ? CA : 4'($urandom);
            sel = $urandom_range(9, 0);
            n   = (sel < 7) ? 17 : (sel < 9 ? $urandom_range(16, 1) : $urandom_range(21, 18));
            frame(a, 12'($urandom), n, "R2/R3/R6 random frame");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule